// File: doc/BRIEF.md
# RV32 Control-Transfer Execution Unit

This block resolves the control-transfer instructions of the 32-bit base integer instruction set: direct jumps, register-indirect jumps, PC-relative upper-immediate adds and the six conditional branches. Each cycle it takes one instruction word and the program counter of that instruction. It drives the two source-register indices to an external register file and receives the operand values in the same cycle. From these it produces the next program counter, a destination-register write request (enable, index, data) and an illegal flag.

The arithmetic is combinational. A parameter selects whether the outputs go straight to the ports or pass through one register stage with an asynchronous active-low reset. The register file lives outside the block. Only two of its rules matter here: index 0 reads as zero, and a write to index 0 never happens.

Top module: `cxu_unit`

## Requirements
- R1: For opcode 1101111 (jump-and-link) the write data is pc+4 and the next PC is pc plus a sign-extended 21-bit offset. Bit 20 of the offset comes from instr[31], bits 19:12 from instr[19:12], bit 11 from instr[20], bits 10:1 from instr[30:21], and bit 0 is zero.
- R2: For opcode 1100111 (indirect jump) the next PC is the rs1 operand plus the sign-extended instr[31:20], with bit 0 of the sum cleared. The write data is pc+4. The operand is the value read in the same cycle, so a destination equal to rs1 still uses the old base.
- R3: For opcode 0010111 (upper immediate plus PC) the write data is pc + {instr[31:12], 12'b0}, with the addition wrapping modulo 2^32. The next PC is pc+4.
- R4: For opcode 1100011 with funct3 = instr[14:12] equal to 000 (equal) or 001 (not equal), a taken branch goes to pc plus the branch offset and a not-taken branch goes to pc+4. The branch offset is sign-extended from instr[31] and is built as follows: bit 12 from instr[31], bit 11 from instr[7], bits 10:5 from instr[30:25], bits 4:1 from instr[11:8], and bit 0 zero.
- R5: funct3 100 (less than) and 101 (greater or equal) compare the two operands as signed two's-complement values.
- R6: funct3 110 (less than) and 111 (greater or equal) compare the two operands as unsigned values.
- R7: A branch with funct3 010 or 011 raises illegal, keeps the next PC equal to pc and requests no write.
- R8: Any opcode other than the four listed above raises illegal, keeps the next PC equal to pc and requests no write.
- R9: A source index of 0 gives an operand of zero, whatever value arrives on the read-data port.
- R10: The write enable is high only for the jump-and-link, indirect-jump and upper-immediate opcodes, and only when rd = instr[11:7] is nonzero. Branches never write. The write index is instr[11:7].
- R11: The read index rs1 is instr[19:15] and the read index rs2 is instr[24:20], both driven combinationally.
- R12: With REG_OUT=1, every output shows the result for the inputs present at the previous rising clock edge. During reset, next_pc is 0 and wr_en and illegal are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| rs1_idx | output | 5 | First register-file read index |
| rs1_data | input | XLEN | First register-file read data |
| rs2_idx | output | 5 | Second register-file read index |
| rs2_data | input | XLEN | Second register-file read data |
| next_pc | output | XLEN | Program counter after this instruction |
| wr_en | output | 1 | Destination write request |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | XLEN | Value to write (link value or PC-relative sum) |
| illegal | output | 1 | Encoding not handled by this unit |

## Verification
The bench builds two instances side by side, both with XLEN=32: `dut` with REG_OUT=1 and `dut_comb` with REG_OUT=0. Every vector is checked on both, which covers both the pass-through and the registered variant of the output stage. While a second instruction is driven, the registered instance must still show the first result and the combinational instance must already show the second. That exposes the one-cycle delay of R12. A bench register file that holds a nonzero value at index 0 makes the zero-operand rule of R9 visible at the ports.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;

  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  localparam logic [2:0] F3_EQ  = 3'b000;
  localparam logic [2:0] F3_NE  = 3'b001;
  localparam logic [2:0] F3_LT  = 3'b100;
  localparam logic [2:0] F3_GE  = 3'b101;
  localparam logic [2:0] F3_LTU = 3'b110;
  localparam logic [2:0] F3_GEU = 3'b111;

  typedef enum logic [2:0] {
    XK_NONE,
    XK_JAL,
    XK_JALR,
    XK_AUIPC,
    XK_BRANCH
  } xfer_kind_e;

  // Offset of a direct jump, sign-extended to 32 bits.
  function automatic logic [31:0] imm_jump(input logic [INSN_W-1:0] w);
    logic [31:0] r;
    r          = '0;
    r[19:12]   = w[19:12];
    r[11]      = w[20];
    r[10:1]    = w[30:21];
    r[31:20]   = {12{w[31]}};
    return r;
  endfunction

  // Offset of a conditional branch, sign-extended to 32 bits.
  function automatic logic [31:0] imm_branch(input logic [INSN_W-1:0] w);
    logic [31:0] r;
    r          = '0;
    r[4:1]     = w[11:8];
    r[10:5]    = w[30:25];
    r[11]      = w[7];
    r[31:12]   = {20{w[31]}};
    return r;
  endfunction

  // 12-bit immediate of an indirect jump, sign-extended.
  function automatic logic [31:0] imm_short(input logic [INSN_W-1:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  // Upper immediate, already shifted into place.
  function automatic logic [31:0] imm_upper(input logic [INSN_W-1:0] w);
    return {w[31:12], 12'h000};
  endfunction

endpackage

// File: rtl/cxu_decode.sv
module cxu_decode
  import cxu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output xfer_kind_e        kind,
  output logic              op_unknown,
  output logic [2:0]        f3,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  rs1,
  output logic [IDX_W-1:0]  rs2,
  output logic [31:0]       imm
);

  assign f3  = instr[14:12];
  assign rd  = instr[11:7];
  assign rs1 = instr[19:15];
  assign rs2 = instr[24:20];

  always_comb begin
    kind       = XK_NONE;
    op_unknown = 1'b0;
    imm        = '0;
    unique case (instr[6:0])
      OPC_JAL: begin
        kind = XK_JAL;
        imm  = imm_jump(instr);
      end
      OPC_JALR: begin
        kind = XK_JALR;
        imm  = imm_short(instr);
      end
      OPC_AUIPC: begin
        kind = XK_AUIPC;
        imm  = imm_upper(instr);
      end
      OPC_BRANCH: begin
        kind = XK_BRANCH;
        imm  = imm_branch(instr);
      end
      default: op_unknown = 1'b1;
    endcase
  end

endmodule

// File: rtl/cxu_branch_cmp.sv
module cxu_branch_cmp
  import cxu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      f3,
  output logic            taken,
  output logic            f3_bad
);

  logic is_eq;
  logic lt_signed;
  logic lt_unsigned;

  assign is_eq       = (a == b);
  assign lt_signed   = ($signed(a) < $signed(b));
  assign lt_unsigned = (a < b);

  always_comb begin
    taken  = 1'b0;
    f3_bad = 1'b0;
    unique case (f3)
      F3_EQ:   taken = is_eq;
      F3_NE:   taken = !is_eq;
      F3_LT:   taken = lt_signed;
      F3_GE:   taken = !lt_signed;
      F3_LTU:  taken = lt_unsigned;
      F3_GEU:  taken = !lt_unsigned;
      default: f3_bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/cxu_target.sv
module cxu_target
  import cxu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  xfer_kind_e      kind,
  input  logic [31:0]     imm,
  input  logic [XLEN-1:0] base,
  input  logic            taken,
  input  logic            hold,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link_val
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] off;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] ind_pc;

  assign off    = XLEN'($signed(imm));
  assign seq_pc = pc + STEP;
  assign rel_pc = pc + off;

  always_comb begin
    ind_pc    = base + off;
    ind_pc[0] = 1'b0;
  end

  always_comb begin
    if (hold) begin
      next_pc = pc;
    end else begin
      unique case (kind)
        XK_JAL:    next_pc = rel_pc;
        XK_JALR:   next_pc = ind_pc;
        XK_AUIPC:  next_pc = seq_pc;
        XK_BRANCH: next_pc = taken ? rel_pc : seq_pc;
        default:   next_pc = pc;
      endcase
    end
  end

  assign link_val = (kind == XK_AUIPC) ? rel_pc : seq_pc;

endmodule

// File: rtl/cxu_out_stage.sv
module cxu_out_stage #(
  parameter int XLEN    = 32,
  parameter int IDX_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  d_next_pc,
  input  logic             d_wr_en,
  input  logic [IDX_W-1:0] d_wr_idx,
  input  logic [XLEN-1:0]  d_wr_data,
  input  logic             d_illegal,
  output logic [XLEN-1:0]  q_next_pc,
  output logic             q_wr_en,
  output logic [IDX_W-1:0] q_wr_idx,
  output logic [XLEN-1:0]  q_wr_data,
  output logic             q_illegal
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_next_pc <= '0;
          q_wr_en   <= 1'b0;
          q_wr_idx  <= '0;
          q_wr_data <= '0;
          q_illegal <= 1'b0;
        end else begin
          q_next_pc <= d_next_pc;
          q_wr_en   <= d_wr_en;
          q_wr_idx  <= d_wr_idx;
          q_wr_data <= d_wr_data;
          q_illegal <= d_illegal;
        end
      end
    end else begin : g_pass
      assign q_next_pc = d_next_pc;
      assign q_wr_en   = d_wr_en;
      assign q_wr_idx  = d_wr_idx;
      assign q_wr_data = d_wr_data;
      assign q_illegal = d_illegal;
    end
  endgenerate

endmodule

// File: rtl/cxu_unit.sv
module cxu_unit
  import cxu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INSN_W-1:0]     instr,
  input  logic [XLEN-1:0]       pc,
  output logic [IDX_W-1:0]      rs1_idx,
  input  logic [XLEN-1:0]       rs1_data,
  output logic [IDX_W-1:0]      rs2_idx,
  input  logic [XLEN-1:0]       rs2_data,
  output logic [XLEN-1:0]       next_pc,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [XLEN-1:0]       wr_data,
  output logic                  illegal
);

  xfer_kind_e      kind;
  logic            op_unknown;
  logic [2:0]      f3;
  logic [IDX_W-1:0] rd;
  logic [31:0]     imm;

  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic            br_taken;
  logic            br_f3_bad;

  // Combinational results, named for the checker.
  logic            c_illegal;
  logic            c_wr_en;
  logic [XLEN-1:0] c_next_pc;
  logic [XLEN-1:0] c_link;

  cxu_decode u_dec (
    .instr      (instr),
    .kind       (kind),
    .op_unknown (op_unknown),
    .f3         (f3),
    .rd         (rd),
    .rs1        (rs1_idx),
    .rs2        (rs2_idx),
    .imm        (imm)
  );

  // Index 0 is hard zero regardless of the read port.
  assign op_a = (rs1_idx == '0) ? '0 : rs1_data;
  assign op_b = (rs2_idx == '0) ? '0 : rs2_data;

  cxu_branch_cmp #(.XLEN(XLEN)) u_cmp (
    .a      (op_a),
    .b      (op_b),
    .f3     (f3),
    .taken  (br_taken),
    .f3_bad (br_f3_bad)
  );

  assign c_illegal = op_unknown || ((kind == XK_BRANCH) && br_f3_bad);

  cxu_target #(.XLEN(XLEN)) u_tgt (
    .pc       (pc),
    .kind     (kind),
    .imm      (imm),
    .base     (op_a),
    .taken    (br_taken),
    .hold     (c_illegal),
    .next_pc  (c_next_pc),
    .link_val (c_link)
  );

  assign c_wr_en = ((kind == XK_JAL) || (kind == XK_JALR) || (kind == XK_AUIPC))
                   && (rd != '0);

  cxu_out_stage #(.XLEN(XLEN), .IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_next_pc (c_next_pc),
    .d_wr_en   (c_wr_en),
    .d_wr_idx  (rd),
    .d_wr_data (c_link),
    .d_illegal (c_illegal),
    .q_next_pc (next_pc),
    .q_wr_en   (wr_en),
    .q_wr_idx  (wr_idx),
    .q_wr_data (wr_data),
    .q_illegal (illegal)
  );

endmodule

// File: rtl/cxu_chk.sv
module cxu_chk
  import cxu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [XLEN-1:0]  pc,
  input xfer_kind_e       kind,
  input logic [XLEN-1:0]  c_next_pc,
  input logic             c_wr_en,
  input logic             c_illegal,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]  next_pc
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R10
  wr_idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

  // R10
  branch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == XK_BRANCH) |-> !c_wr_en);

  // R7
  illegal_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_illegal |-> (c_next_pc == pc));

  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_illegal |-> !c_wr_en);

  // R2
  jalr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == XK_JALR) |-> (c_next_pc[0] == 1'b0));

  generate
    if (REG_OUT) begin : g_pipe
      // R12
      pipe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (next_pc == $past(c_next_pc)));
    end
  endgenerate

endmodule

bind cxu_unit cxu_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc        (pc),
  .kind      (kind),
  .c_next_pc (c_next_pc),
  .c_wr_en   (c_wr_en),
  .c_illegal (c_illegal),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .next_pc   (next_pc)
);

// File: tb/tb_cxu_unit.sv
module tb_cxu_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr = 32'h0;
  logic [31:0] pc    = 32'h0;
  logic [31:0] rf [32];

  logic [4:0]  r_rs1_idx, r_rs2_idx, r_wr_idx, c_rs1_idx, c_rs2_idx, c_wr_idx;
  logic [31:0] r_rs1_data, r_rs2_data, c_rs1_data, c_rs2_data;
  logic [31:0] r_next_pc, r_wr_data, c_next_pc, c_wr_data;
  logic        r_wr_en, r_illegal, c_wr_en, c_illegal;

  assign r_rs1_data = rf[r_rs1_idx];
  assign r_rs2_data = rf[r_rs2_idx];
  assign c_rs1_data = rf[c_rs1_idx];
  assign c_rs2_data = rf[c_rs2_idx];

  cxu_unit #(.XLEN(32), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
    .rs1_idx(r_rs1_idx), .rs1_data(r_rs1_data),
    .rs2_idx(r_rs2_idx), .rs2_data(r_rs2_data),
    .next_pc(r_next_pc), .wr_en(r_wr_en), .wr_idx(r_wr_idx),
    .wr_data(r_wr_data), .illegal(r_illegal));

  cxu_unit #(.XLEN(32), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
    .rs1_idx(c_rs1_idx), .rs1_data(c_rs1_data),
    .rs2_idx(c_rs2_idx), .rs2_data(c_rs2_data),
    .next_pc(c_next_pc), .wr_en(c_wr_en), .wr_idx(c_wr_idx),
    .wr_data(c_wr_data), .illegal(c_illegal));

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Encoders.
  function automatic logic [31:0] e_jal(input logic [4:0] rd, input logic [20:0] o);
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] e_jalr(input logic [4:0] rd, input logic [4:0] rs, input logic [11:0] i);
    return {i, rs, 3'b000, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] e_auipc(input logic [4:0] rd, input logic [19:0] u);
    return {u, rd, 7'b0010111};
  endfunction
  function automatic logic [31:0] e_br(input logic [2:0] f, input logic [4:0] a, input logic [4:0] b,
                                       input logic [12:0] o);
    return {o[12], o[10:5], b, a, f, o[4:1], o[11], 7'b1100011};
  endfunction

  // Independent reference model.
  task automatic model(input logic [31:0] w, input logic [31:0] p,
                       output logic [31:0] nxt, output logic we,
                       output logic [31:0] wd, output logic ill);
    logic [31:0] a, b, jo, bo, io;
    logic        t;
    a  = (w[19:15] == 5'd0) ? 32'd0 : rf[w[19:15]];
    b  = (w[24:20] == 5'd0) ? 32'd0 : rf[w[24:20]];
    jo = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    bo = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    io = {{20{w[31]}}, w[31:20]};
    nxt = p; we = 1'b0; wd = 32'd0; ill = 1'b1;
    case (w[6:0])
      7'b1101111: begin ill = 0; nxt = p + jo; wd = p + 4; we = (w[11:7] != 0); end
      7'b1100111: begin ill = 0; nxt = (a + io) & 32'hFFFF_FFFE; wd = p + 4; we = (w[11:7] != 0); end
      7'b0010111: begin ill = 0; nxt = p + 4; wd = p + {w[31:12], 12'd0}; we = (w[11:7] != 0); end
      7'b1100011: begin
        ill = 0; t = 0;
        case (w[14:12])
          3'd0: t = (a == b);
          3'd1: t = (a != b);
          3'd4: t = (a[31] != b[31]) ? a[31] : (a < b);
          3'd5: t = !((a[31] != b[31]) ? a[31] : (a < b));
          3'd6: t = (a < b);
          3'd7: t = (a >= b);
          default: ill = 1;
        endcase
        if (!ill) nxt = t ? p + bo : p + 4;
      end
      default: ;
    endcase
  endtask

  task automatic check_outs(input string tag, input logic [31:0] w, input logic [31:0] nxt,
                            input logic we, input logic [31:0] wd, input logic ill);
    chk({tag, " reg next_pc"}, r_next_pc, nxt);
    chk({tag, " reg wr_en"},   {31'd0, r_wr_en}, {31'd0, we});
    chk({tag, " reg illegal"}, {31'd0, r_illegal}, {31'd0, ill});
    chk({tag, " reg wr_idx (R10)"}, {27'd0, r_wr_idx}, {27'd0, w[11:7]});
    if (we) chk({tag, " reg wr_data"}, r_wr_data, wd);
    chk({tag, " comb next_pc"}, c_next_pc, nxt);
    chk({tag, " comb wr_en"},   {31'd0, c_wr_en}, {31'd0, we});
    chk({tag, " comb illegal"}, {31'd0, c_illegal}, {31'd0, ill});
    if (we) chk({tag, " comb wr_data"}, c_wr_data, wd);
  endtask

  // Apply one instruction at a negedge, check after the next rising edge.
  task automatic run(input string tag, input logic [31:0] w, input logic [31:0] p);
    logic [31:0] nxt, wd;
    logic we, ill;
    model(w, p, nxt, we, wd, ill);
    instr = w; pc = p;
    @(posedge clk); @(negedge clk);
    check_outs(tag, w, nxt, we, wd, ill);
    if (we) rf[w[11:7]] = wd;
  endtask

  task automatic t_reset();
    instr = e_jal(5'd1, 21'h100); pc = 32'h1000;
    #1;
    chk("R12 reset next_pc", r_next_pc, 32'd0);
    chk("R12 reset wr_en",   {31'd0, r_wr_en}, 32'd0);
    chk("R12 reset illegal", {31'd0, r_illegal}, 32'd0);
  endtask

  task automatic t_jal();
    run("R1 jal forward",  e_jal(5'd1, 21'h0_0804), 32'h0000_2000);
    run("R1 jal backward", e_jal(5'd2, 21'h1F_FFF0), 32'h0000_2000);
    run("R1 jal max neg",  e_jal(5'd3, 21'h10_0000), 32'h0040_0000);
    run("R10 jal rd0 no write", e_jal(5'd0, 21'h0_0010), 32'h0000_0100);
  endtask

  task automatic t_jalr();
    rf[5] = 32'h0000_1001;
    run("R2 jalr rd==rs1 old base odd", e_jalr(5'd5, 5'd5, 12'h008), 32'h0000_3000);
    rf[6] = 32'h0000_4000;
    run("R2 jalr negative imm", e_jalr(5'd7, 5'd6, 12'hFFC), 32'h0000_3010);
    run("R9 jalr base x0", e_jalr(5'd8, 5'd0, 12'h123), 32'h0000_5000);
  endtask

  task automatic t_auipc();
    run("R3 auipc positive", e_auipc(5'd9, 20'h12345), 32'h0000_0040);
    run("R3 auipc negative wrap", e_auipc(5'd10, 20'hFFFFF), 32'h0000_0800);
    run("R10 auipc rd0", e_auipc(5'd0, 20'h00001), 32'h0000_0900);
  endtask

  task automatic t_branch_eq();
    rf[11] = 32'h55; rf[12] = 32'h55; rf[13] = 32'h56;
    run("R4 beq taken",     e_br(3'd0, 5'd11, 5'd12, 13'h040), 32'h0000_6000);
    run("R4 beq not taken", e_br(3'd0, 5'd11, 5'd13, 13'h040), 32'h0000_6000);
    run("R4 bne taken back", e_br(3'd1, 5'd11, 5'd13, 13'h1F00), 32'h0000_6000);
    run("R4 bne not taken", e_br(3'd1, 5'd11, 5'd12, 13'h1F00), 32'h0000_6000);
    run("R9 beq x0 vs x0",  e_br(3'd0, 5'd0, 5'd0, 13'h0820), 32'h0000_7000);
  endtask

  task automatic t_branch_order();
    rf[14] = 32'hFFFF_FFFF; rf[15] = 32'h0000_0001;
    run("R5 blt signed taken",   e_br(3'd4, 5'd14, 5'd15, 13'h010), 32'h0000_8000);
    run("R5 bge signed not",     e_br(3'd5, 5'd14, 5'd15, 13'h010), 32'h0000_8000);
    run("R5 bge equal taken",    e_br(3'd5, 5'd15, 5'd15, 13'h010), 32'h0000_8000);
    run("R6 bltu unsigned not",  e_br(3'd6, 5'd14, 5'd15, 13'h010), 32'h0000_8000);
    run("R6 bgeu unsigned taken", e_br(3'd7, 5'd14, 5'd15, 13'h010), 32'h0000_8000);
    run("R6 bltu equal not",     e_br(3'd6, 5'd15, 5'd15, 13'h010), 32'h0000_8000);
  endtask

  task automatic t_illegal();
    run("R7 branch f3 010", e_br(3'd2, 5'd1, 5'd2, 13'h020), 32'h0000_9000);
    run("R7 branch f3 011", e_br(3'd3, 5'd1, 5'd2, 13'h020), 32'h0000_9004);
    run("R8 opcode addi",   32'h0010_0093, 32'h0000_9008);
    run("R8 opcode zero",   32'h0000_0000, 32'h0000_900C);
  endtask

  task automatic t_ports();
    instr = e_br(3'd0, 5'd19, 5'd27, 13'h0); #1;
    chk("R11 rs1_idx", {27'd0, c_rs1_idx}, 32'd19);
    chk("R11 rs2_idx", {27'd0, c_rs2_idx}, 32'd27);
  endtask

  task automatic t_pipe();
    logic [31:0] na, nb, wa, wb, w1, w2;
    logic ea, eb, ia, ib;
    w1 = e_jal(5'd4, 21'h0_0100);
    w2 = e_auipc(5'd4, 20'h00002);
    model(w1, 32'h0000_A000, na, ea, wa, ia);
    model(w2, 32'h0000_B000, nb, eb, wb, ib);
    instr = w1; pc = 32'h0000_A000;
    @(posedge clk); @(negedge clk);
    instr = w2; pc = 32'h0000_B000; #1;
    chk("R12 reg holds previous", r_next_pc, na);
    chk("R12 comb shows current", c_next_pc, nb);
    @(posedge clk); @(negedge clk);
    chk("R12 reg updated", r_next_pc, nb);
    chk("R12 reg wr_data updated", r_wr_data, wb);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h0100_0000 + i;
    rf[0] = 32'hDEAD_BEEF;
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ports();
    t_jal();
    t_jalr();
    t_auipc();
    t_branch_eq();
    t_branch_order();
    t_illegal();
    t_pipe();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule